// File: doc/BRIEF.md
# Segment Base-Limit Translator

This block maps a 14-bit virtual address to a physical address through a table of four segment entries. Each entry holds a physical base, a segment size and a read-only flag. The upper two address bits choose the entry and the lower twelve bits give the offset inside the segment. An access whose offset lies inside the segment and that does not break the entry's protection returns base plus offset. Any other access returns a fault with a cause code and no address.

The table is loaded through a write port that updates one entry per cycle. Requests carry a valid strobe and a write flag. Every valid request produces exactly one registered response on the next cycle. A parameter can compile out the protection check and leave only the bounds check.

Top module: `seg_xlat`

## Requirements
- R1: A virtual address is split as segment number = vaddr[13:12] and offset = vaddr[11:0]. The offset is zero-extended before it is added to the base.
- R2: When the offset is below the selected segment's size and protection allows the access, the response carries paddr = (base + offset) modulo 2^16, fault = 0 and cause = 2'b00.
- R3: When the offset is equal to or greater than the segment's size, the response carries fault = 1, cause = 2'b01 and paddr = 0.
- R4: A segment whose size is zero counts as unused, so every access to it faults with cause 2'b01.
- R5: A write (req_write = 1) to an in-range offset of a read-only entry faults with cause 2'b10 and paddr = 0. Reads of read-only entries and writes to read-write entries translate normally.
- R6: When an access is both out of range and a write to a read-only entry, the response reports cause 2'b01. The code 2'b11 never appears.
- R7: The response appears exactly one cycle after a valid request. In a cycle that follows no valid request, rsp_valid, rsp_fault, rsp_paddr and rsp_cause are all zero.
- R8: A table write changes the translation of requests from the following cycle on. A request in the same cycle as the write still uses the old entry.
- R9: After reset every entry has size zero, base zero and is read-write, and the response outputs are zero.
- R10: A table write changes only the entry selected by cfg_seg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_seg | input | 2 | Entry to write |
| cfg_base | input | 16 | Physical base for the entry |
| cfg_size | input | 13 | Segment size in bytes (0 to 4096) |
| cfg_ro | input | 1 | 1 makes the entry read-only |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | 14 | Virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_paddr | output | 16 | Translated address, zero on a fault |
| rsp_fault | output | 1 | Access was refused |
| rsp_cause | output | 2 | 00 none, 01 out of bounds, 10 protection |

## Verification
The assertions assume that req_valid, req_write and cfg_we stay low while reset is asserted, because the response and fault checks look back one cycle across the reset release. The bench holds every input at zero through reset and changes stimulus only on falling clock edges. Table writes are mixed with requests, including requests to the entry being written in the same cycle, so the one-cycle visibility rule is exercised without breaking those assumptions.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_BOUND = 2'b01,
      CAUSE_PROT  = 2'b10
   } fault_cause_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_BITS = 2,
   parameter int SIZE_W   = 13,
   parameter int PA_BITS  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEG_BITS-1:0] wr_idx,
   input  logic [PA_BITS-1:0]  wr_base,
   input  logic [SIZE_W-1:0]   wr_size,
   input  logic                wr_ro,
   input  logic [SEG_BITS-1:0] rd_idx,
   output logic [PA_BITS-1:0]  rd_base,
   output logic [SIZE_W-1:0]   rd_size,
   output logic                rd_ro
);
   localparam int NUM_SEG = 1 << SEG_BITS;

   logic [PA_BITS-1:0] base_q [NUM_SEG];
   logic [SIZE_W-1:0]  size_q [NUM_SEG];
   logic               ro_q   [NUM_SEG];

   // one register slice per entry; R10: only the addressed slice loads
   for (genvar e = 0; e < NUM_SEG; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == SEG_BITS'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[e] <= '0;
            size_q[e] <= '0;   // R9: every entry starts unused
            ro_q[e]   <= 1'b0;
         end else if (hit) begin
            base_q[e] <= wr_base;
            size_q[e] <= wr_size;
            ro_q[e]   <= wr_ro;
         end
      end
   end

   // R8: read returns the registered entry, so a same-cycle write is not seen
   assign rd_base = base_q[rd_idx];
   assign rd_size = size_q[rd_idx];
   assign rd_ro   = ro_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlat_pkg::*;
#(
   parameter int OFF_BITS = 12,
   parameter int SIZE_W   = 13,
   parameter int PA_BITS  = 16,
   parameter bit PROT_EN  = 1'b1
) (
   input  logic                access_write,
   input  logic [OFF_BITS-1:0] offset,
   input  logic [PA_BITS-1:0]  base,
   input  logic [SIZE_W-1:0]   size,
   input  logic                ro,
   output logic [PA_BITS-1:0]  paddr,
   output fault_cause_e        cause
);
   logic beyond;
   logic prot_bad;
   logic [PA_BITS-1:0] sum;

   // R3/R4: compare in the wider size domain; size 0 makes every offset beyond
   assign beyond = (SIZE_W'(offset) >= size);
   // R1/R2: zero-extended offset plus base, wrapping at the address width
   assign sum    = base + PA_BITS'(offset);

   if (PROT_EN) begin : g_prot
      assign prot_bad = access_write && ro;          // R5
   end else begin : g_noprot
      assign prot_bad = 1'b0;
   end

   always_comb begin
      // R6: bounds outranks protection
      if (beyond) begin
         cause = CAUSE_BOUND;
         paddr = '0;
      end else if (prot_bad) begin
         cause = CAUSE_PROT;
         paddr = '0;
      end else begin
         cause = CAUSE_NONE;
         paddr = sum;
      end
   end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
   import seg_xlat_pkg::*;
#(
   parameter int SEG_BITS = 2,
   parameter int OFF_BITS = 12,
   parameter int PA_BITS  = 16,
   parameter bit PROT_EN  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [SEG_BITS-1:0]          cfg_seg,
   input  logic [PA_BITS-1:0]           cfg_base,
   input  logic [OFF_BITS:0]            cfg_size,
   input  logic                         cfg_ro,
   input  logic                         req_valid,
   input  logic                         req_write,
   input  logic [SEG_BITS+OFF_BITS-1:0] req_vaddr,
   output logic                         rsp_valid,
   output logic [PA_BITS-1:0]           rsp_paddr,
   output logic                         rsp_fault,
   output logic [1:0]                   rsp_cause
);
   localparam int VA_BITS = SEG_BITS + OFF_BITS;
   localparam int SIZE_W  = OFF_BITS + 1;

   if (SEG_BITS < 1 || SEG_BITS > 6) begin : g_bad_seg
      $error("seg_xlat: SEG_BITS must be 1..6");
   end
   if (OFF_BITS < 1) begin : g_bad_off
      $error("seg_xlat: OFF_BITS must be positive");
   end
   if (PA_BITS < OFF_BITS) begin : g_bad_pa
      $error("seg_xlat: PA_BITS must cover the offset");
   end

   logic [SEG_BITS-1:0] seg_idx;
   logic [OFF_BITS-1:0] seg_off;
   logic [PA_BITS-1:0]  ent_base;
   logic [SIZE_W-1:0]   ent_size;
   logic                ent_ro;
   logic [PA_BITS-1:0]  chk_paddr;
   fault_cause_e        chk_cause;

   // R1: segment number on top, offset below
   assign seg_idx = req_vaddr[VA_BITS-1:OFF_BITS];
   assign seg_off = req_vaddr[OFF_BITS-1:0];

   seg_table #(
      .SEG_BITS(SEG_BITS), .SIZE_W(SIZE_W), .PA_BITS(PA_BITS)
   ) i_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_seg), .wr_base(cfg_base),
      .wr_size(cfg_size), .wr_ro(cfg_ro),
      .rd_idx(seg_idx), .rd_base(ent_base), .rd_size(ent_size), .rd_ro(ent_ro)
   );

   seg_check #(
      .OFF_BITS(OFF_BITS), .SIZE_W(SIZE_W), .PA_BITS(PA_BITS), .PROT_EN(PROT_EN)
   ) i_check (
      .access_write(req_write), .offset(seg_off),
      .base(ent_base), .size(ent_size), .ro(ent_ro),
      .paddr(chk_paddr), .cause(chk_cause)
   );

   // R7: single response stage, cleared when no request was taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
         rsp_cause <= CAUSE_NONE;
      end else if (req_valid) begin
         rsp_valid <= 1'b1;
         rsp_paddr <= chk_paddr;
         rsp_fault <= (chk_cause != CAUSE_NONE);
         rsp_cause <= chk_cause;
      end else begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
         rsp_cause <= CAUSE_NONE;
      end
   end

   a_r7_req_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r7_rsp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_fault && rsp_paddr == '0 && rsp_cause == 2'b00));
   a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0 && rsp_cause != 2'b00));
   a_r5_prot_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cause == 2'b10) |-> $past(req_write));
   a_r6_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cause != 2'b11);

endmodule

// File: tb/test_seg_xlat.sv
module test_seg_xlat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_seg = '0;
   logic [15:0] cfg_base = '0;
   logic [12:0] cfg_size = '0;
   logic        cfg_ro = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [13:0] req_vaddr = '0;
   logic        rsp_valid;
   logic [15:0] rsp_paddr;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int m_base [4];
   int m_size [4];
   bit m_ro   [4];

   logic        e_valid = 0, e_fault = 0;
   logic [15:0] e_paddr = '0;
   logic [1:0]  e_cause = '0;
   string       e_tag = "R9";

   always #2.5 clk = ~clk;

   seg_xlat i_seg_xlat (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_base(cfg_base),
      .cfg_size(cfg_size), .cfg_ro(cfg_ro),
      .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );

   task automatic compare();
      checks++;
      if (rsp_valid !== e_valid || rsp_paddr !== e_paddr ||
          rsp_fault !== e_fault || rsp_cause !== e_cause) begin
         fails++;
         $display("FAIL %s: got v=%0b pa=%h f=%0b c=%0b, expected v=%0b pa=%h f=%0b c=%0b",
                  e_tag, rsp_valid, rsp_paddr, rsp_fault, rsp_cause,
                  e_valid, e_paddr, e_fault, e_cause);
      end
   endtask

   // one cycle: check the previous response, apply new inputs, predict
   task automatic step(input bit v, input bit w, input logic [13:0] va,
                       input bit we, input logic [1:0] cs, input logic [15:0] cb,
                       input logic [12:0] csz, input bit cro, input string tag);
      int seg, off;
      @(negedge clk);
      compare();
      req_valid = v; req_write = w; req_vaddr = va;
      cfg_we = we; cfg_seg = cs; cfg_base = cb; cfg_size = csz; cfg_ro = cro;
      seg = int'(va[13:12]);
      off = int'(va[11:0]);
      e_tag = tag;
      e_valid = v; e_paddr = '0; e_fault = 0; e_cause = 2'b00;
      if (v) begin
         if (off >= m_size[seg]) begin
            e_fault = 1; e_cause = 2'b01;
         end else if (w && m_ro[seg]) begin
            e_fault = 1; e_cause = 2'b10;
         end else begin
            e_paddr = 16'((m_base[seg] + off) & 16'hFFFF);
         end
      end
      if (we) begin
         m_base[int'(cs)] = int'(cb);
         m_size[int'(cs)] = int'(csz);
         m_ro[int'(cs)]   = cro;
      end
   endtask

   task automatic rq(input bit w, input logic [1:0] s, input int off, input string tag);
      step(1, w, {s, 12'(off)}, 0, 2'd0, 16'd0, 13'd0, 0, tag);
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] b, input int sz,
                     input bit ro, input string tag);
      step(0, 0, 14'd0, 1, s, b, 13'(sz), ro, tag);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run hung, got timeout, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_base[i] = 0; m_size[i] = 0; m_ro[i] = 0;
      end
      repeat (3) @(negedge clk);
      compare();                           // R9 outputs zero in reset
      rst_n = 1'b1;
      // R9 / R4: after reset every entry is unused
      rq(0, 2'd0, 0, "R9");
      rq(1, 2'd3, 5, "R4");
      // R8: write seg1 and request it in the same cycle, old entry applies
      step(1, 0, {2'd1, 12'h010}, 1, 2'd1, 16'h0000, 13'h500, 0, "R8");
      rq(0, 2'd1, 'h010, "R8");
      wr(2'd0, 16'h4000, 'h700, 1, "R10");
      wr(2'd3, 16'h2000, 'h1000, 0, "R10");
      // R2 / R1 normal translation
      rq(0, 2'd0, 'h000, "R2");
      rq(0, 2'd0, 'h6ff, "R2");
      rq(0, 2'd3, 'hfff, "R1");
      rq(1, 2'd1, 'h4ff, "R2");
      // R3 boundary
      rq(0, 2'd0, 'h700, "R3");
      rq(1, 2'd1, 'h500, "R3");
      // R5 protection
      rq(1, 2'd0, 'h123, "R5");
      rq(0, 2'd0, 'h123, "R5");
      // R6 priority
      rq(1, 2'd0, 'h800, "R6");
      // R4 unused segment
      rq(0, 2'd2, 'h000, "R4");
      // R7 idle gap then back to back
      step(0, 0, 14'd0, 0, 2'd0, 16'd0, 13'd0, 0, "R7");
      step(0, 1, {2'd3, 12'h001}, 0, 2'd0, 16'd0, 13'd0, 0, "R7");
      rq(0, 2'd3, 'h001, "R7");
      rq(1, 2'd3, 'h002, "R7");
      // R2 wraparound of the physical address
      wr(2'd2, 16'hFF00, 'h1000, 0, "R2");
      rq(0, 2'd2, 'h200, "R2");
      // R10 rewrite seg1 and confirm seg3 unchanged
      wr(2'd1, 16'h9000, 'h20, 1, "R10");
      rq(0, 2'd3, 'h400, "R10");
      rq(1, 2'd1, 'h10, "R10");
      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0], r[1], 14'($urandom), (r[4:2] == 3'd0), r[6:5],
              16'($urandom), 13'($urandom_range(0, 4096)), r[7], "R2");
      end
      step(0, 0, 14'd0, 0, 2'd0, 16'd0, 13'd0, 0, "R7");
      @(negedge clk);
      compare();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule